// File: doc/BRIEF.md
# Exclusion-Masked Memory Tag Generator

This block produces a small memory tag, four bits wide by default, on request. A caller places a start tag, a step count and a sixteen-bit exclusion set on the inputs and pulses `start_i`. In deterministic mode the block walks forward from the start tag, wrapping modulo sixteen. It never settles on a tag whose bit is set in the exclusion set, and it returns the tag it reaches. In random mode it ignores the start tag and the step count. It draws the starting point from an internal sixteen-bit shift register, then moves forward past excluded values only. When every value is excluded the answer is always zero.

The walk is sequential, with one tag increment or one shift-register step per clock. `busy_o` is high while an operation runs. `done_o` pulses for one cycle, and `tag_o` then holds the result until the next operation ends. The shift-register state can be written through `seed_wr_i`/`seed_i` and read on `seed_o`, so software can save and restore it.

Top module: `mask_tag_gen`

## Requirements
- R1: In deterministic mode with step count zero, the result is the start tag if its exclusion bit is clear; otherwise it is the first tag above it, wrapping from 15 to 0, whose bit is clear.
- R2: In deterministic mode with step count k > 0, the block repeats k times: one increment, then further increments while the current tag's exclusion bit is set. The start tag itself is not checked against the set.
- R3: If all sixteen exclusion bits are set, `done_o` rises in the cycle after the start. The result is 0, and the shift register does not advance, even in random mode.
- R4: One shift-register step computes the new bit as s[5]^s[3]^s[2]^s[0]. It shifts the register right by one and places the new bit at bit 15.
- R5: In random mode the tag is built from four successive new bits, the first going to tag bit 0 and the last to tag bit 3. The R1 walk with step count zero is then applied to it.
- R6: Each tag increment and each shift-register step takes exactly one clock. For a start sampled at edge E0, `done_o` is seen after edge E0+n+1 in deterministic mode and E0+n+5 in random mode, where n is the number of increments.
- R7: `busy_o` is high from the start edge until the edge that raises `done_o`. `done_o` is high for exactly one cycle and never while `busy_o` is high.
- R8: A `start_i` pulse while `busy_o` is high is ignored. It changes neither the running operation's result nor its timing.
- R9: `seed_wr_i` loads `seed_i` into the shift register, visible on `seed_o` after the next edge. Outside random draws the register holds its value.
- R10: After reset `busy_o` and `done_o` are 0, `tag_o` is 0 and `seed_o` is 16'hACE1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (sampled only when idle) |
| rand_mode_i | input | 1 | 1 = random start tag, 0 = deterministic |
| tag_i | input | TAG_W | Start tag for deterministic mode |
| offset_i | input | TAG_W | Step count for deterministic mode |
| excl_i | input | 2**TAG_W | Exclusion set, bit i excludes tag i |
| seed_wr_i | input | 1 | Load strobe for the shift register |
| seed_i | input | SEED_W | Value to load |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| tag_o | output | TAG_W | Result tag |
| seed_o | output | SEED_W | Current shift-register state |

## Verification
The bench sweeps every start tag against a set of step counts and exclusion patterns. Each result and latency is compared with an arithmetic model. A design that checked the start tag when the step count is nonzero, or skipped only once per step, would return a tag one or more places off. The worst case uses step count 15 with a single free tag at every position. There a miscounted step or a wrap bug shows up as a wrong tag or a latency that differs from 16 increments per step. Random draws are checked against a software model of the shift register, including bit order into the tag and the frozen seed under an all-excluded set. Start pulses injected mid-operation must leave the result and latency untouched.

// File: rtl/mtg_pkg.sv
package mtg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAW,
    ST_WALK
  } mtg_state_e;
endpackage

// File: rtl/mtg_lfsr.sv
module mtg_lfsr #(
  parameter int unsigned W        = 16,
  parameter logic [W-1:0] TAPS    = 16'h002D,
  parameter logic [W-1:0] RST_VAL = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic [W-1:0] state_o,
  output logic         bit_o
);
  logic [W-1:0] q;

  assign bit_o   = ^(q & TAPS);
  assign state_o = q;

  // load wins over step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= RST_VAL;
    else if (load_i) q <= load_val_i;
    else if (step_i) q <= {bit_o, q[W-1:1]};
  end
endmodule

// File: rtl/mtg_step.sv
module mtg_step #(
  parameter int unsigned TAG_W = 4,
  localparam int unsigned NTAGS = 1 << TAG_W
) (
  input  logic [TAG_W-1:0] tag_i,
  input  logic [NTAGS-1:0] excl_i,
  input  logic             skip_en_i,
  input  logic [TAG_W-1:0] off_i,
  output logic             inc_o,
  output logic             dec_off_o,
  output logic             fin_o
);
  logic skip, steps_left;

  always_comb begin
    skip       = skip_en_i && excl_i[tag_i];
    steps_left = (off_i != '0);
    inc_o      = skip || steps_left;
    dec_off_o  = !skip && steps_left;
    fin_o      = !inc_o;
  end
endmodule

// File: rtl/mask_tag_gen.sv
module mask_tag_gen
  import mtg_pkg::*;
#(
  parameter int unsigned TAG_W   = 4,
  parameter int unsigned SEED_W  = 16,
  parameter logic [SEED_W-1:0] SEED_TAPS = 16'h002D,
  parameter logic [SEED_W-1:0] SEED_RST  = 16'hACE1,
  localparam int unsigned NTAGS  = 1 << TAG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rand_mode_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [TAG_W-1:0]  offset_i,
  input  logic [NTAGS-1:0]  excl_i,
  input  logic              seed_wr_i,
  input  logic [SEED_W-1:0] seed_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [SEED_W-1:0] seed_o
);
  localparam int unsigned CNT_W = (TAG_W > 1) ? $clog2(TAG_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TAG_W - 1);

  mtg_state_e       state_q;
  logic [TAG_W-1:0] tag_q, off_q, res_q;
  logic [NTAGS-1:0] excl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             skip_q, done_q;
  logic             rnd_bit, inc, dec_off, fin;

  mtg_lfsr #(
    .W       (SEED_W),
    .TAPS    (SEED_TAPS),
    .RST_VAL (SEED_RST)
  ) u_lfsr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (seed_wr_i),
    .load_val_i (seed_i),
    .step_i     (state_q == ST_DRAW),
    .state_o    (seed_o),
    .bit_o      (rnd_bit)
  );

  mtg_step #(.TAG_W(TAG_W)) u_step (
    .tag_i     (tag_q),
    .excl_i    (excl_q),
    .skip_en_i (skip_q),
    .off_i     (off_q),
    .inc_o     (inc),
    .dec_off_o (dec_off),
    .fin_o     (fin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tag_q   <= '0;
      off_q   <= '0;
      res_q   <= '0;
      excl_q  <= '0;
      cnt_q   <= '0;
      skip_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            excl_q <= excl_i;
            if (&excl_i) begin
              res_q  <= '0;
              done_q <= 1'b1;
            end else if (rand_mode_i) begin
              state_q <= ST_DRAW;
              tag_q   <= '0;
              off_q   <= '0;
              cnt_q   <= '0;
              skip_q  <= 1'b1;
            end else begin
              state_q <= ST_WALK;
              tag_q   <= tag_i;
              off_q   <= offset_i;
              skip_q  <= (offset_i == '0);
            end
          end
        end
        ST_DRAW: begin
          tag_q[cnt_q] <= rnd_bit;
          cnt_q        <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) state_q <= ST_WALK;
        end
        ST_WALK: begin
          if (inc) begin
            tag_q  <= tag_q + 1'b1;
            skip_q <= 1'b1;
          end
          if (dec_off) off_q <= off_q - 1'b1;
          if (fin) begin
            res_q   <= tag_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign tag_o  = res_q;

  // R3
  all_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (&excl_i) && !seed_wr_i) |=> (done_o && tag_o == '0 && $stable(seed_o)));

  // R1
  res_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(&excl_q)) |-> !excl_q[tag_o]);

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R7
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));

  // R9
  seed_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_wr_i |=> (seed_o == $past(seed_i)));

  // R9
  seed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !seed_wr_i) |=> $stable(seed_o));
endmodule

// File: tb/mask_tag_gen_bench.sv
module mask_tag_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, rand_mode = 1'b0, seed_wr = 1'b0;
  logic [3:0]  tag_in = '0, off_in = '0;
  logic [15:0] excl_in = '0, seed_in = '0;
  logic        busy, done;
  logic [3:0]  tag_out;
  logic [15:0] seed_out;

  int n_chk = 0, n_fail = 0;
  logic [15:0] model_seed;

  always #10 clk = ~clk;

  mask_tag_gen u_mask_tag_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rand_mode_i(rand_mode),
    .tag_i(tag_in), .offset_i(off_in), .excl_i(excl_in),
    .seed_wr_i(seed_wr), .seed_i(seed_in),
    .busy_o(busy), .done_o(done), .tag_o(tag_out), .seed_o(seed_out)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] s, output logic b);
    b = s[5] ^ s[3] ^ s[2] ^ s[0];
    return {b, s[15:1]};
  endfunction

  task automatic ref_walk(input logic [3:0] t0, input logic [3:0] o0, input logic [15:0] m,
                          output logic [3:0] r, output int n);
    logic [3:0] t = t0;
    logic [3:0] o = o0;
    n = 0;
    if (&m) begin r = '0; return; end
    if (o == 0) while (m[t]) begin t++; n++; end
    while (o != 0) begin
      o--; t++; n++;
      while (m[t]) begin t++; n++; end
    end
    r = t;
  endtask

  task automatic load_seed(input logic [15:0] s);
    @(negedge clk); seed_wr = 1'b1; seed_in = s;
    @(negedge clk); seed_wr = 1'b0;
    model_seed = s;
    chk(seed_out == s, "R9", "seed readback", seed_out, s);
  endtask

  task automatic run_op(input bit rm, input logic [3:0] t, input logic [3:0] o,
                        input logic [15:0] m, input bit inj, input string req);
    logic [3:0] exp_tag, start_t;
    logic [15:0] exp_seed;
    logic b;
    int n, exp_lat, lat;
    exp_seed = model_seed;
    start_t  = t;
    if (rm && !(&m)) begin
      for (int i = 0; i < 4; i++) begin
        exp_seed   = lfsr_next(exp_seed, b);
        start_t[i] = b;
      end
    end
    ref_walk(start_t, rm ? 4'd0 : o, m, exp_tag, n);
    exp_lat = (&m) ? 0 : (rm ? n + 5 : n + 1);

    @(negedge clk);
    rand_mode = rm; tag_in = t; off_in = o; excl_in = m; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy == !(&m), "R7", "busy after start", busy, !(&m));
    lat = 0;
    while (!done && lat < 600) begin
      if (inj && lat == 1) begin
        start = 1'b1; tag_in = t + 4'd5; off_in = o + 4'd3; excl_in = 16'h0; rand_mode = ~rm;
      end else start = 1'b0;
      @(posedge clk); #1;
      lat++;
    end
    start = 1'b0;
    chk(done == 1'b1, req, "done seen", done, 1);
    chk(tag_out == exp_tag, req, "result tag", tag_out, exp_tag);
    chk(lat == exp_lat, inj ? "R8" : "R6", "latency", lat, exp_lat);
    chk(seed_out == exp_seed, rm ? "R5" : "R9", "seed after op", seed_out, exp_seed);
    model_seed = exp_seed;
    @(posedge clk); #1;
    chk(done == 1'b0, "R7", "done width", done, 0);
    chk(busy == 1'b0, "R7", "idle after done", busy, 0);
  endtask

  initial begin
    #(20 * 190000);
    n_fail++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] masks [8];
    logic [3:0]  offs [5];
    masks = '{16'h0000, 16'hFFFF, 16'hAAAA, 16'h5555, 16'h7FFF, 16'hFFFE, 16'h0F0F, 16'h8001};
    offs  = '{4'd0, 4'd1, 4'd2, 4'd7, 4'd15};
    model_seed = 16'hACE1;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(busy == 0, "R10", "busy in reset", busy, 0);
    chk(done == 0, "R10", "done in reset", done, 0);
    chk(tag_out == 0, "R10", "tag in reset", tag_out, 0);
    chk(seed_out == 16'hACE1, "R10", "seed in reset", seed_out, 16'hACE1);
    @(negedge clk); rst_n = 1'b1;

    // R4 R5 draws from the reset seed
    for (int i = 0; i < 8; i++) run_op(1'b1, 4'd0, 4'd0, masks[i], 1'b0, "R5");

    // R1 R2 R3 deterministic sweep
    for (int t = 0; t < 16; t++)
      for (int oi = 0; oi < 5; oi++)
        for (int mi = 0; mi < 8; mi++)
          run_op(1'b0, 4'(t), offs[oi], masks[mi], 1'b0, offs[oi] == 0 ? "R1" : "R2");

    // R2 R6 worst case: step 15, one free tag
    for (int c = 0; c < 16; c++)
      for (int t = 0; t < 16; t++)
        run_op(1'b0, 4'(t), 4'd15, ~(16'h1 << c), 1'b0, "R2");

    // R9 seed load, then R4 R5 random draws
    load_seed(16'h1234);
    for (int i = 0; i < 64; i++) run_op(1'b1, 4'(i), 4'(i), masks[i % 8], 1'b0, "R4");
    load_seed(16'h8001);
    for (int c = 0; c < 16; c++) run_op(1'b1, 4'd0, 4'd0, ~(16'h1 << c), 1'b0, "R5");

    // R3 random with all excluded: seed frozen
    run_op(1'b1, 4'd3, 4'd3, 16'hFFFF, 1'b0, "R3");

    // R8 start while busy
    run_op(1'b0, 4'd2, 4'd15, 16'hFF7F, 1'b1, "R8");
    run_op(1'b0, 4'd9, 4'd4, 16'h00F0, 1'b1, "R8");
    run_op(1'b1, 4'd0, 4'd0, 16'hFFF0, 1'b1, "R8");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule